// File: doc/BRIEF.md
# Multi-address I2C memory target engine

This block is the serial target side of one I2C port in front of a shared byte memory. It watches SCL and SDA, recognises START and STOP, and answers at three 7-bit device addresses. The memory address pair carries word-offset writes, page writes, random reads and sequential reads. The segment pointer address takes one byte that selects a 256-byte segment. The configuration address pair takes a write of a dummy byte followed by the data byte, and a one-byte read.

Memory writes are collected in a page buffer and are committed to the shared memory only after STOP. A busy window then follows, and while it lasts the engine does not acknowledge any device address. The mapping of banks and the arbitration between ports are handled outside this block. The engine reaches the memory through a plain address, read strobe, write strobe and data interface, and it pulls SDA low through an open-drain enable.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, sda_oe_o, busy_o and mem_wr_o are 0 and cfg_o holds the parameter CFG_INIT (default FFh).
- R2: The engine acknowledges the address bytes A0h and A1h (memory), 60h (segment pointer) and 62h and 63h (configuration). It does not acknowledge 61h or any other address byte, and it then ignores the bus until the next START.
- R3: For a transaction START, A0h, offset, data, STOP, the data byte is written to the memory address {segment, offset}. The segment is the upper SEG_W bits of the address and the offset is the low 8 bits.
- R4: In a page write every data byte is acknowledged. The low 4 bits of the offset advance after each byte and wrap within the 16-byte page, and the upper offset bits stay fixed. A later byte that lands on the same slot replaces the earlier one.
- R5: Buffered bytes reach the memory only after STOP. mem_wr_o stays 0 during the transaction, then pulses once for each distinct page slot that was filled, and never in the same cycle as mem_rd_o.
- R6: A read at A1h returns the byte at {segment, offset}. Each byte that the master acknowledges advances the 8-bit offset, and the offset wraps from FFh to 00h within the same segment.
- R7: When the master does not acknowledge a read byte, the engine releases SDA and leaves it released until the next START.
- R8: A write at 60h stores the low SEG_W bits of the next byte as the segment, and this segment applies to the accesses that follow a repeated START. STOP returns the segment to 0.
- R9: A write at 62h takes a dummy byte and then a data byte, and the data byte becomes cfg_o. A read at 63h returns cfg_o.
- R10: When wr_allow_i is 0, the data bytes of a memory write are not acknowledged. No memory write takes place and no busy window follows, but the offset byte is still acknowledged.
- R11: After a STOP that closes a transaction in which a memory or configuration write was accepted, busy_o is 1 for exactly BUSY_CYCLES clocks. Every address byte received during that time is not acknowledged.
- R12: The engine changes sda_oe_o only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| wr_allow_i | input | 1 | 1 permits data bytes of memory writes |
| mem_rd_o | output | 1 | Memory read strobe; data must follow mem_addr_o within one clock |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | SEG_W+8 | Memory address {segment, offset} |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| cfg_o | output | 8 | Configuration register value |
| busy_o | output | 1 | Internal write window active |

## Verification
A table of single-byte writes, each to a different segment and offset and each read back through a random read, separates a correct segment and offset concatenation from one that drops or swaps bits. Without the pointer, a read of the same offset shows that STOP clears the segment. An 18-byte page write that starts two slots below the page end tells page wrapping apart from a carry into the upper offset bits, and it also tells overwriting apart from appending. The write strobe count taken before and after STOP shows that commits are deferred. Other cases cover a sequential read across FFh, a master NACK followed by one more clocked byte, unknown addresses, the 61h address, writes refused by wr_allow_i, and an address sent during the busy window. Each of these is one of the ways the engine decides whether to acknowledge.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } phase_e;

    typedef enum logic [2:0] {
        CX_DEV,
        CX_OFF,
        CX_DATA,
        CX_SEG,
        CX_CDUM,
        CX_CDAT
    } ctx_e;

    localparam logic [6:0] DEV_MEM = 7'h50;
    localparam logic [6:0] DEV_SEG = 7'h30;
    localparam logic [6:0] DEV_CFG = 7'h31;

endpackage

// File: rtl/i2ct_bus_sense.sv
module i2ct_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_s_o
);
    typedef struct packed {
        logic scl_m;
        logic sda_m;
        logic scl_s;
        logic sda_s;
        logic scl_p;
        logic sda_p;
    } sense_t;

    sense_t q, d;

    always_comb begin
        d.scl_m = scl_i;
        d.sda_m = sda_i;
        d.scl_s = q.scl_m;
        d.sda_s = q.sda_m;
        d.scl_p = q.scl_s;
        d.sda_p = q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_rise_o = q.scl_s & ~q.scl_p;
    assign scl_fall_o = ~q.scl_s & q.scl_p;
    assign start_o    = q.scl_s & q.scl_p & q.sda_p & ~q.sda_s;
    assign stop_o     = q.scl_s & q.scl_p & ~q.sda_p & q.sda_s;
    assign sda_s_o    = q.sda_s;
endmodule

// File: rtl/i2ct_busy_timer.sv
module i2ct_busy_timer #(
    parameter int BUSY_CYCLES = 2000,
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic busy_o
);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (arm_i)             cnt_d = CW'(BUSY_CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - {{(CW-1){1'b0}}, 1'b1};
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2ct_page_buf.sv
module i2ct_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int ADDR_W = 10,
    localparam int IDX_W = $clog2(PAGE_BYTES),
    localparam int BASE_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put_i,
    input  logic [IDX_W-1:0]  put_idx_i,
    input  logic [7:0]        put_data_i,
    input  logic              commit_i,
    input  logic [BASE_W-1:0] base_i,
    output logic              wr_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              active_o
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      vld;
        logic                       run;
        logic [IDX_W-1:0]           idx;
        logic [BASE_W-1:0]          base;
    } pbuf_t;

    pbuf_t q, d;

    always_comb begin
        d = q;
        if (put_i) begin
            d.data[put_idx_i] = put_data_i;
            d.vld[put_idx_i]  = 1'b1;
        end
        if (commit_i) begin
            d.run  = 1'b1;
            d.idx  = '0;
            d.base = base_i;
        end else if (q.run) begin
            d.vld[q.idx] = 1'b0;
            d.idx        = q.idx + {{(IDX_W-1){1'b0}}, 1'b1};
            if (q.idx == IDX_W'(PAGE_BYTES - 1)) d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_o      = q.run & q.vld[q.idx];
    assign wr_addr_o = {q.base, q.idx};
    assign wr_data_o = q.data[q.idx];
    assign active_o  = q.run;
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2ct_pkg::*;
#(
    parameter int SEG_W = 2,
    parameter int PAGE_BYTES = 16,
    parameter int BUSY_CYCLES = 2000,
    parameter logic [7:0] CFG_INIT = 8'hFF,
    localparam int ADDR_W = SEG_W + 8,
    localparam int IDX_W = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wr_allow_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [7:0]        cfg_o,
    output logic              busy_o
);
    typedef struct packed {
        phase_e           st;
        phase_e           nxt;
        ctx_e             cx;
        logic [3:0]       cnt;
        logic [7:0]       sr;
        logic             ack;
        logic             mack;
        logic             txcfg;
        logic [SEG_W-1:0] seg;
        logic [7:0]       off;
        logic             wpend;
        logic             cpend;
        logic [7:0]       cfg;
    } eng_t;

    eng_t q, d;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic put_en, commit, arm_busy, ok;
    logic pb_wr, pb_active;
    logic [ADDR_W-1:0] pb_addr;
    logic [7:0] pb_data;

    i2ct_bus_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .sda_s_o    (sda_s)
    );

    i2ct_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (arm_busy),
        .busy_o (busy_o)
    );

    i2ct_page_buf #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_pbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .put_i      (put_en),
        .put_idx_i  (q.off[IDX_W-1:0]),
        .put_data_i (q.sr),
        .commit_i   (commit),
        .base_i     ({q.seg, q.off[7:IDX_W]}),
        .wr_o       (pb_wr),
        .wr_addr_o  (pb_addr),
        .wr_data_o  (pb_data),
        .active_o   (pb_active)
    );

    always_comb begin
        d        = q;
        put_en   = 1'b0;
        commit   = 1'b0;
        arm_busy = 1'b0;
        ok       = 1'b0;
        if (start_det) begin
            d.st  = ST_RX;
            d.cx  = CX_DEV;
            d.cnt = '0;
            d.ack = 1'b0;
        end else if (stop_det) begin
            d.st     = ST_IDLE;
            d.cx     = CX_DEV;
            d.ack    = 1'b0;
            d.seg    = '0;
            d.wpend  = 1'b0;
            d.cpend  = 1'b0;
            arm_busy = q.wpend | q.cpend;
            commit   = q.wpend;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt != 4'd8) begin
                        d.sr  = {q.sr[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.nxt = ST_RX;
                        case (q.cx)
                            CX_DEV: begin
                                if (busy_o) begin
                                    ok = 1'b0;
                                end else if (q.sr[7:1] == DEV_MEM) begin
                                    ok      = 1'b1;
                                    d.txcfg = 1'b0;
                                    d.cx    = CX_OFF;
                                    if (q.sr[0]) d.nxt = ST_TX;
                                end else if (q.sr[7:1] == DEV_SEG) begin
                                    ok   = ~q.sr[0];
                                    d.cx = CX_SEG;
                                end else if (q.sr[7:1] == DEV_CFG) begin
                                    ok      = 1'b1;
                                    d.txcfg = 1'b1;
                                    d.cx    = CX_CDUM;
                                    if (q.sr[0]) d.nxt = ST_TX;
                                end
                            end
                            CX_OFF: begin
                                ok    = 1'b1;
                                d.off = q.sr;
                                d.cx  = CX_DATA;
                            end
                            CX_DATA: begin
                                ok = wr_allow_i;
                                if (wr_allow_i) begin
                                    put_en  = 1'b1;
                                    d.wpend = 1'b1;
                                    d.off   = {q.off[7:IDX_W],
                                               q.off[IDX_W-1:0] + {{(IDX_W-1){1'b0}}, 1'b1}};
                                end
                            end
                            CX_SEG: begin
                                ok    = 1'b1;
                                d.seg = q.sr[SEG_W-1:0];
                                d.nxt = ST_WAIT;
                            end
                            CX_CDUM: begin
                                ok   = 1'b1;
                                d.cx = CX_CDAT;
                            end
                            CX_CDAT: begin
                                ok      = 1'b1;
                                d.cfg   = q.sr;
                                d.cpend = 1'b1;
                                d.nxt   = ST_WAIT;
                            end
                            default: ok = 1'b0;
                        endcase
                        d.st  = ST_RX_ACK;
                        d.ack = ok;
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.ack = 1'b0;
                        d.cnt = '0;
                        if (!q.ack) begin
                            d.st = ST_WAIT;
                        end else begin
                            d.st = q.nxt;
                            if (q.nxt == ST_TX) d.sr = q.txcfg ? q.cfg : mem_rdata_i;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.st  = ST_TX_ACK;
                            d.cnt = '0;
                            if (!q.txcfg) d.off = q.off + 8'd1;
                        end else begin
                            d.sr  = {q.sr[6:0], 1'b0};
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = ST_TX;
                            d.cnt = '0;
                            d.sr  = q.txcfg ? q.cfg : mem_rdata_i;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.nxt <= ST_IDLE;
            q.cx  <= CX_DEV;
            q.cfg <= CFG_INIT;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = (q.st == ST_RX_ACK && q.ack) || (q.st == ST_TX && !q.sr[7]);
    assign mem_rd_o    = !pb_active && !q.txcfg &&
                         ((q.st == ST_RX_ACK && q.ack && q.nxt == ST_TX) || q.st == ST_TX_ACK);
    assign mem_wr_o    = pb_wr;
    assign mem_addr_o  = pb_active ? pb_addr : {q.seg, q.off};
    assign mem_wdata_o = pb_data;
    assign cfg_o       = q.cfg;
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe_o,
    input logic busy_o,
    input logic mem_wr_o,
    input logic mem_rd_o,
    input logic stop_det
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i); // R12

    AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> busy_o); // R5

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_o && mem_rd_o)); // R5

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_det)); // R11

    AST_SILENT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o); // R11
endmodule

bind i2c_mem_target i2ct_checker chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .mem_wr_o (mem_wr_o),
    .mem_rd_o (mem_rd_o),
    .stop_det (stop_det)
);

// File: tb/i2c_mem_target_test.sv
`timescale 1ns/1ps
module i2c_mem_target_test;
    localparam int Q    = 8;
    localparam int BUSY = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wr_allow = 1'b1;
    logic sda_oe, mem_rd, mem_wr, busy;
    logic [9:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, cfg;
    logic sda_bus;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_mem_target #(.BUSY_CYCLES(BUSY)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .wr_allow_i  (wr_allow),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .cfg_o       (cfg),
        .busy_o      (busy)
    );

    logic [7:0] mem [1024];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
            mem[10'h010] <= 8'h3C;
            mem[10'h040] <= 8'h44;
            mem[10'h0FE] <= 8'hA1;
            mem[10'h0FF] <= 8'hA2;
            mem[10'h000] <= 8'hA3;
            mem[10'h100] <= 8'hEE;
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr];

    logic cnt_clr = 1'b0;
    int busy_cnt, wr_cnt, viol;
    logic prev_scl, prev_oe;
    always @(posedge clk) begin
        if (cnt_clr) begin
            busy_cnt <= 0;
            wr_cnt   <= 0;
        end else begin
            if (busy)   busy_cnt <= busy_cnt + 1;
            if (mem_wr) wr_cnt   <= wr_cnt + 1;
        end
        if (!rst_n) begin
            viol <= 0;
        end else if (scl && prev_scl && sda_oe != prev_oe) begin
            viol <= viol + 1;
        end
        prev_scl <= scl;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clear_counts();
        cnt_clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; qw();
        scl = 1'b1; qw(); qw();
        m_sda = 1'b0; qw(); qw();
        scl = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; qw();
        scl = 1'b1; qw(); qw();
        m_sda = 1'b1; qw(); qw();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw();
            scl = 1'b1; qw(); qw();
            scl = 1'b0; qw();
        end
        m_sda = 1'b1; qw();
        scl = 1'b1; qw();
        ack = ~sda_bus;
        qw();
        scl = 1'b0; qw();
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            scl = 1'b1; qw();
            b[i] = sda_bus;
            qw();
            scl = 1'b0; qw();
        end
        m_sda = ~mack; qw();
        scl = 1'b1; qw(); qw();
        scl = 1'b0; qw();
    endtask

    task automatic wait_free();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_at(input logic use_seg, input logic [1:0] seg,
                         input logic [7:0] off, output logic [7:0] val, output logic acks);
        logic a;
        acks = 1'b1;
        if (use_seg) begin
            i2c_start();
            wr_byte(8'h60, a); acks &= a;
            wr_byte({6'b0, seg}, a); acks &= a;
        end
        i2c_start();
        wr_byte(8'hA0, a); acks &= a;
        wr_byte(off, a); acks &= a;
        i2c_start();
        wr_byte(8'hA1, a); acks &= a;
        rd_byte(1'b0, val);
        i2c_stop();
    endtask

    // stimulus {segment, offset, data}; expected read-back equals data
    localparam logic [17:0] VEC [6] = '{
        {2'd0, 8'h05, 8'h11},
        {2'd1, 8'h05, 8'h22},
        {2'd2, 8'h10, 8'h5A},
        {2'd3, 8'hFF, 8'h33},
        {2'd1, 8'h80, 8'h44},
        {2'd3, 8'h00, 8'h55}
    };

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a, acks;
        logic [7:0] v;
        logic [1:0] sg;
        logic [7:0] of, dt;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1 reset state
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 mem_wr", int'(mem_wr), 0);
        chk("R1 cfg", int'(cfg), 8'hFF);

        // R3 / R8 table of single-byte writes with read-back
        for (int k = 0; k < 6; k++) begin
            {sg, of, dt} = VEC[k];
            acks = 1'b1;
            i2c_start();
            wr_byte(8'h60, a); acks &= a;
            wr_byte({6'b0, sg}, a); acks &= a;
            i2c_start();
            wr_byte(8'hA0, a); acks &= a;
            wr_byte(of, a); acks &= a;
            wr_byte(dt, a); acks &= a;
            i2c_stop();
            wait_free();
            chk("R3 write acks", int'(acks), 1);
            chk("R3 memory content", int'(mem[{sg, of}]), int'(dt));
            rd_at(1'b1, sg, of, v, a);
            chk("R8 segmented read-back", int'(v), int'(dt));
        end

        // R8 segment cleared by STOP
        rd_at(1'b0, 2'd0, 8'h10, v, a);
        chk("R8 segment back to zero", int'(v), 8'h3C);

        // R4 / R5 / R11 page write from slot E, 18 bytes
        clear_counts();
        acks = 1'b1;
        i2c_start();
        wr_byte(8'hA0, a); acks &= a;
        wr_byte(8'h2E, a); acks &= a;
        for (int i = 0; i < 18; i++) begin
            wr_byte(8'(8'h80 + i), a);
            acks &= a;
        end
        chk("R4 page acks", int'(acks), 1);
        chk("R5 no write before stop", wr_cnt, 0);
        i2c_stop();
        i2c_start();
        wr_byte(8'hA1, a);
        chk("R11 address refused while busy", int'(a), 0);
        i2c_stop();
        wait_free();
        chk("R5 write pulses", wr_cnt, 16);
        chk("R11 busy length", busy_cnt, BUSY);
        for (int s = 0; s < 16; s++) begin
            chk("R4 page slot", int'(mem[10'h020 + s]), int'(8'h80 + ((s + 2) % 16) + (s >= 14 ? 16 : 0)));
        end
        chk("R4 next page untouched", int'(mem[10'h030]), 0);

        // R6 / R7 sequential read wrapping in segment 0
        i2c_start();
        wr_byte(8'hA0, a);
        wr_byte(8'hFE, a);
        i2c_start();
        wr_byte(8'hA1, a);
        rd_byte(1'b1, v); chk("R6 seq byte0", int'(v), 8'hA1);
        rd_byte(1'b1, v); chk("R6 seq byte1", int'(v), 8'hA2);
        rd_byte(1'b0, v); chk("R6 seq wrap", int'(v), 8'hA3);
        rd_byte(1'b0, v); chk("R7 released after nack", int'(v), 8'hFF);
        i2c_stop();

        // R9 configuration write and read
        clear_counts();
        acks = 1'b1;
        i2c_start();
        wr_byte(8'h62, a); acks &= a;
        wr_byte(8'h00, a); acks &= a;
        wr_byte(8'h35, a); acks &= a;
        i2c_stop();
        chk("R9 cfg write acks", int'(acks), 1);
        chk("R9 cfg output", int'(cfg), 8'h35);
        wait_free();
        chk("R11 busy after cfg write", busy_cnt, BUSY);
        i2c_start();
        wr_byte(8'h63, a);
        chk("R2 63h acked", int'(a), 1);
        rd_byte(1'b0, v);
        i2c_stop();
        chk("R9 cfg read", int'(v), 8'h35);

        // R2 refused addresses
        i2c_start();
        wr_byte(8'h61, a);
        chk("R2 61h refused", int'(a), 0);
        wr_byte(8'h12, a);
        chk("R2 bus ignored after refusal", int'(a), 0);
        i2c_stop();
        i2c_start();
        wr_byte(8'hA4, a);
        chk("R2 unknown address refused", int'(a), 0);
        i2c_stop();
        chk("R2 no busy after refusals", int'(busy), 0);

        // R10 writes refused when not allowed
        clear_counts();
        wr_allow = 1'b0;
        i2c_start();
        wr_byte(8'hA0, a);
        chk("R10 address acked", int'(a), 1);
        wr_byte(8'h40, a);
        chk("R10 offset acked", int'(a), 1);
        wr_byte(8'h77, a);
        chk("R10 data refused", int'(a), 0);
        i2c_stop();
        repeat (20) @(negedge clk);
        chk("R10 no busy", int'(busy), 0);
        chk("R10 no write pulse", wr_cnt, 0);
        chk("R10 memory unchanged", int'(mem[10'h040]), 8'h44);
        wr_allow = 1'b1;

        // R12 SDA held while SCL high
        chk("R12 sda changes during scl high", viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule